// File: doc/BRIEF.md
# Multi-Speed Ethernet Activity LED Controller

This block turns the link state and traffic pulses of a 100/1000/2500 Mbps Ethernet port into three LED drive levels. Each LED owns two configuration words: a steady rule word, which picks the link speeds that light it and holds its enable and polarity, and an activity word, which picks the speed and direction combinations whose traffic pulses make it blink. When nothing speed-specific is selected, a manual force-on or force-blink bit takes over instead.

Blinking is timed in units of an external `tick` strobe. One shared register sets the blink period and another sets the lit part of each period. Setup software normally writes half the period into the lit-time register. A matching traffic pulse starts a period, and further pulses inside a period carry the pattern on for one more period. While a period runs, the LED shows the blink pattern in place of its steady state. A global control word can stop all LEDs or freeze the blink timing. Configuration arrives over a simple parallel write port. Every output is registered, so an output reflects the inputs and state of the previous clock.

Top module: `eth_led_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every `led_o` bit is 0. Reset loads the defaults: control word 0x8009, blink period 1562 ticks, lit time 781 ticks, steady words 0xC103/0xC101/0xC102, activity words 0x0000/0x0C03/0x0C0C for LED0/1/2. Each output is registered, so it reflects inputs and state one clock later.
- R2: Writes with `cfg_we` high go to these addresses: 0 = control, 1 = blink period, 2 = lit time, 4+2i = steady word of LED i, 5+2i = activity word of LED i. In the steady word, bit 1 lights the LED on a link at 100 Mbps, bit 0 at 1000 Mbps and bit 8 at 2500 Mbps. `link_speed` is coded 0 = 100, 1 = 1000, 2 = 2500 and 3 = no speed. There is no match when `link_up` is low or the code is 3.
- R3: Steady word bit 14 is the polarity. A lit LED drives the polarity value and an unlit LED drives its inverse.
- R4: When steady word bit 15 (enable) is 0, the LED drives its inactive level.
- R5: When control bit 15 is 0, or control bits 1:0 are 00, every LED drives its inactive level.
- R6: An activity pulse starts a blink period when `link_up` is high and the activity word selects it. The selecting bits are: 100 Mbps TX bit 2 and RX bit 3; 1000 Mbps TX bit 0 and RX bit 1; 2500 Mbps TX bit 10 and RX bit 11. `act_tx`/`act_rx` are indexed 0 = 100, 1 = 1000, 2 = 2500. A period lasts the blink period in ticks (at least one). The LED is lit while the tick count within the period is below the lit time and dark after that.
- R7: A matching pulse that arrives during a period (or on its last tick) makes a new period start right after the current one. Without such a pulse, the LED returns to its steady state.
- R8: Steady bit 6 (force-on) lights the LED only when no speed-specific bit is set, that is none of steady bits 0/1/8 and none of activity bits 0-3/10/11. Otherwise it has no effect.
- R9: Activity bit 9 (force-blink) blinks the LED continuously, period after period, under the same condition as R8. Otherwise it has no effect.
- R10: Control bit 3 is the timing enable. While it is 0, ticks do not advance any blink period.
- R11: With the reset defaults, LED0 is lit on a link at any speed. LED1 is lit at 2500 or 1000 Mbps and blinks on traffic at those speeds. LED2 is lit at 2500 or 100 Mbps and blinks on traffic at those speeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Duration unit strobe for blink timing |
| link_up | input | 1 | Link is established |
| link_speed | input | 2 | Speed code: 0 = 100, 1 = 1000, 2 = 2500, 3 = none |
| act_tx | input | 3 | Transmit activity pulses per speed (bit 0 = 100, 1 = 1000, 2 = 2500) |
| act_rx | input | 3 | Receive activity pulses per speed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| led_o | output | 3 | LED drive levels, one per LED |

## Verification
The assertions assume that `rst_n` is applied before any meaningful traffic. They also assume that a force-blink LED sees its control flag stay stable long enough for the restart rule to hold across a period boundary. Apart from that, they rely only on activity pulses and ticks being single-cycle levels sampled at the clock. The stimulus always drives every input to a known value one half-cycle before the edge. It keeps the programmed blink periods short (mostly 1 to 12 ticks, with one run at the default length) so that starts, extensions and ends of periods all happen many times, and it mixes rare configuration writes into the random traffic.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

    localparam int REG_W      = 16;
    localparam int NUM_SPEEDS = 3;

    // Speed codes on the link_speed input
    typedef enum logic [1:0] {
        SPD_100  = 2'd0,
        SPD_1000 = 2'd1,
        SPD_2500 = 2'd2,
        SPD_NONE = 2'd3
    } speed_e;

    // Steady word bit positions
    localparam int ST_L1000 = 0;
    localparam int ST_L100  = 1;
    localparam int ST_FORCE = 6;
    localparam int ST_L2500 = 8;
    localparam int ST_POL   = 14;
    localparam int ST_EN    = 15;

    // Activity word bit positions
    localparam int AC_1000TX = 0;
    localparam int AC_1000RX = 1;
    localparam int AC_100TX  = 2;
    localparam int AC_100RX  = 3;
    localparam int AC_FORCE  = 9;
    localparam int AC_2500TX = 10;
    localparam int AC_2500RX = 11;

    // Control word bit positions
    localparam int CT_MODE_LO = 0;
    localparam int CT_MODE_HI = 1;
    localparam int CT_CLKEN   = 3;
    localparam int CT_EXT     = 15;

    typedef struct packed {
        logic en;
        logic pol;
        logic force_on;
        logic l2500;
        logic l1000;
        logic l100;
    } steady_cfg_t;

    // tx/rx vectors indexed by speed: 0 = 100, 1 = 1000, 2 = 2500
    typedef struct packed {
        logic                  force_blink;
        logic [NUM_SPEEDS-1:0] tx;
        logic [NUM_SPEEDS-1:0] rx;
    } act_cfg_t;

    function automatic steady_cfg_t decode_steady(input logic [REG_W-1:0] w);
        steady_cfg_t c;
        c.en       = w[ST_EN];
        c.pol      = w[ST_POL];
        c.force_on = w[ST_FORCE];
        c.l2500    = w[ST_L2500];
        c.l1000    = w[ST_L1000];
        c.l100     = w[ST_L100];
        return c;
    endfunction

    function automatic act_cfg_t decode_act(input logic [REG_W-1:0] w);
        act_cfg_t c;
        c.force_blink = w[AC_FORCE];
        c.tx          = {w[AC_2500TX], w[AC_1000TX], w[AC_100TX]};
        c.rx          = {w[AC_2500RX], w[AC_1000RX], w[AC_100RX]};
        return c;
    endfunction

    // Default steady rules: LED0 any speed, LED1 2500/1000, LED2 2500/100
    function automatic logic [REG_W-1:0] default_steady(input int idx);
        logic [REG_W-1:0] w;
        w = '0;
        if (idx < 3) begin
            w[ST_EN]    = 1'b1;
            w[ST_POL]   = 1'b1;
            w[ST_L2500] = 1'b1;
            w[ST_L1000] = (idx != 2);
            w[ST_L100]  = (idx != 1);
        end
        return w;
    endfunction

    function automatic logic [REG_W-1:0] default_act(input int idx);
        logic [REG_W-1:0] w;
        w = '0;
        if (idx == 1 || idx == 2) begin
            w[AC_2500TX] = 1'b1;
            w[AC_2500RX] = 1'b1;
        end
        if (idx == 1) begin
            w[AC_1000TX] = 1'b1;
            w[AC_1000RX] = 1'b1;
        end
        if (idx == 2) begin
            w[AC_100TX] = 1'b1;
            w[AC_100RX] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/eth_led_regs.sv
module eth_led_regs
    import eth_led_pkg::*;
#(
    parameter int          NUM_LEDS  = 3,
    parameter int          ADDR_W    = 4,
    parameter int          DUR_W     = 16,
    parameter int unsigned RST_BLINK = 1562,
    parameter int unsigned RST_ON    = 781
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [REG_W-1:0]               wdata,
    output logic                           live_o,
    output logic                           clk_en_o,
    output logic [DUR_W-1:0]               blink_dur_o,
    output logic [DUR_W-1:0]               on_dur_o,
    output steady_cfg_t [NUM_LEDS-1:0]     steady_o,
    output act_cfg_t    [NUM_LEDS-1:0]     act_o
);

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_BLINK = 1;
    localparam int ADDR_ON    = 2;
    localparam int LED_BASE   = 4;

    typedef struct packed {
        logic                          ext;
        logic                          clk_en;
        logic [1:0]                    mode;
        logic [DUR_W-1:0]              blink_dur;
        logic [DUR_W-1:0]              on_dur;
        steady_cfg_t [NUM_LEDS-1:0]    steady;
        act_cfg_t    [NUM_LEDS-1:0]    act;
    } regs_t;

    regs_t r_d, r_q;

    function automatic regs_t reset_value();
        regs_t v;
        v.ext       = 1'b1;
        v.clk_en    = 1'b1;
        v.mode      = 2'b01;
        v.blink_dur = DUR_W'(RST_BLINK);
        v.on_dur    = DUR_W'(RST_ON);
        for (int i = 0; i < NUM_LEDS; i++) begin
            v.steady[i] = decode_steady(default_steady(i));
            v.act[i]    = decode_act(default_act(i));
        end
        return v;
    endfunction

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == ADDR_W'(ADDR_CTRL)) begin
                r_d.ext    = wdata[CT_EXT];
                r_d.clk_en = wdata[CT_CLKEN];
                r_d.mode   = wdata[CT_MODE_HI:CT_MODE_LO];
            end
            if (addr == ADDR_W'(ADDR_BLINK)) begin
                r_d.blink_dur = wdata[DUR_W-1:0];
            end
            if (addr == ADDR_W'(ADDR_ON)) begin
                r_d.on_dur = wdata[DUR_W-1:0];
            end
            for (int i = 0; i < NUM_LEDS; i++) begin
                if (addr == ADDR_W'(LED_BASE + 2 * i)) begin
                    r_d.steady[i] = decode_steady(wdata);
                end
                if (addr == ADDR_W'(LED_BASE + 2 * i + 1)) begin
                    r_d.act[i] = decode_act(wdata);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= reset_value();
        end else begin
            r_q <= r_d;
        end
    end

    assign live_o      = r_q.ext && (r_q.mode != 2'b00);
    assign clk_en_o    = r_q.clk_en;
    assign blink_dur_o = r_q.blink_dur;
    assign on_dur_o    = r_q.on_dur;
    assign steady_o    = r_q.steady;
    assign act_o       = r_q.act;

endmodule

// File: rtl/eth_led_rule.sv
module eth_led_rule
    import eth_led_pkg::*;
(
    input  steady_cfg_t            steady_cfg,
    input  act_cfg_t               act_cfg,
    input  logic                   link_up,
    input  logic [1:0]             link_speed,
    input  logic [NUM_SPEEDS-1:0]  act_tx,
    input  logic [NUM_SPEEDS-1:0]  act_rx,
    output logic                   steady_o,
    output logic                   evt_o,
    output logic                   fblink_o
);

    logic link_match;
    logic has_rule;

    always_comb begin
        link_match = 1'b0;
        if (link_up) begin
            case (speed_e'(link_speed))
                SPD_100:  link_match = steady_cfg.l100;
                SPD_1000: link_match = steady_cfg.l1000;
                SPD_2500: link_match = steady_cfg.l2500;
                default:  link_match = 1'b0;
            endcase
        end
    end

    assign has_rule = steady_cfg.l100 | steady_cfg.l1000 | steady_cfg.l2500 |
                      (|act_cfg.tx) | (|act_cfg.rx);

    assign steady_o = link_match | (steady_cfg.force_on & ~has_rule);
    assign evt_o    = link_up & ((|(act_tx & act_cfg.tx)) | (|(act_rx & act_cfg.rx)));
    assign fblink_o = act_cfg.force_blink & ~has_rule;

endmodule

// File: rtl/eth_led_blink.sv
module eth_led_blink #(
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             evt,
    input  logic             fblink,
    input  logic [DUR_W-1:0] blink_dur,
    input  logic [DUR_W-1:0] on_dur,
    output logic             active_o,
    output logic             phase_on_o
);

    typedef struct packed {
        logic             active;
        logic             pend;
        logic [DUR_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic last_tick;

    // Period ends on the tick that brings the count to blink_dur (minimum one tick)
    assign last_tick = ({1'b0, t_q.cnt} + 1'b1) >= {1'b0, blink_dur};

    always_comb begin
        t_d = t_q;
        if (!t_q.active) begin
            if (evt || fblink) begin
                t_d.active = 1'b1;
                t_d.pend   = 1'b0;
                t_d.cnt    = '0;
            end
        end else if (tick_en) begin
            if (last_tick) begin
                t_d.cnt  = '0;
                t_d.pend = 1'b0;
                if (!(t_q.pend || evt || fblink)) begin
                    t_d.active = 1'b0;
                end
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
                if (evt) t_d.pend = 1'b1;
            end
        end else if (evt) begin
            t_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign active_o   = t_q.active;
    assign phase_on_o = t_q.active && (t_q.cnt < on_dur);

endmodule

// File: rtl/eth_led_ctrl.sv
module eth_led_ctrl
    import eth_led_pkg::*;
#(
    parameter int          NUM_LEDS  = 3,
    parameter int          ADDR_W    = 4,
    parameter int          DUR_W     = 16,
    parameter int unsigned RST_BLINK = 1562,
    parameter int unsigned RST_ON    = 781
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  link_up,
    input  logic [1:0]            link_speed,
    input  logic [NUM_SPEEDS-1:0] act_tx,
    input  logic [NUM_SPEEDS-1:0] act_rx,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [REG_W-1:0]      cfg_wdata,
    output logic [NUM_LEDS-1:0]   led_o
);

    logic                        live;
    logic                        clk_en;
    logic                        tick_en;
    logic [DUR_W-1:0]            blink_dur;
    logic [DUR_W-1:0]            on_dur;
    steady_cfg_t [NUM_LEDS-1:0]  steady_cfg;
    act_cfg_t    [NUM_LEDS-1:0]  act_cfg;

    logic [NUM_LEDS-1:0] en_vec;
    logic [NUM_LEDS-1:0] pol_vec;
    logic [NUM_LEDS-1:0] steady_vec;
    logic [NUM_LEDS-1:0] evt_vec;
    logic [NUM_LEDS-1:0] fblink_vec;
    logic [NUM_LEDS-1:0] active_vec;
    logic [NUM_LEDS-1:0] phase_vec;
    logic [NUM_LEDS-1:0] led_d, led_q;

    eth_led_regs #(
        .NUM_LEDS  (NUM_LEDS),
        .ADDR_W    (ADDR_W),
        .DUR_W     (DUR_W),
        .RST_BLINK (RST_BLINK),
        .RST_ON    (RST_ON)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .live_o      (live),
        .clk_en_o    (clk_en),
        .blink_dur_o (blink_dur),
        .on_dur_o    (on_dur),
        .steady_o    (steady_cfg),
        .act_o       (act_cfg)
    );

    assign tick_en = tick & clk_en;

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_led
        assign en_vec[g]  = steady_cfg[g].en;
        assign pol_vec[g] = steady_cfg[g].pol;

        eth_led_rule u_rule (
            .steady_cfg (steady_cfg[g]),
            .act_cfg    (act_cfg[g]),
            .link_up    (link_up),
            .link_speed (link_speed),
            .act_tx     (act_tx),
            .act_rx     (act_rx),
            .steady_o   (steady_vec[g]),
            .evt_o      (evt_vec[g]),
            .fblink_o   (fblink_vec[g])
        );

        eth_led_blink #(
            .DUR_W (DUR_W)
        ) u_blink (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_en    (tick_en),
            .evt        (evt_vec[g]),
            .fblink     (fblink_vec[g]),
            .blink_dur  (blink_dur),
            .on_dur     (on_dur),
            .active_o   (active_vec[g]),
            .phase_on_o (phase_vec[g])
        );
    end

    always_comb begin
        led_d = '0;
        for (int i = 0; i < NUM_LEDS; i++) begin
            logic lit;
            lit = active_vec[i] ? phase_vec[i] : steady_vec[i];
            led_d[i] = (live && en_vec[i] && lit) ? pol_vec[i] : ~pol_vec[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q <= '0;
        end else begin
            led_q <= led_d;
        end
    end

    assign led_o = led_q;

endmodule

// File: rtl/eth_led_ctrl_chk.sv
module eth_led_ctrl_chk #(
    parameter int NUM_LEDS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                live,
    input logic [NUM_LEDS-1:0] en,
    input logic [NUM_LEDS-1:0] pol,
    input logic [NUM_LEDS-1:0] steady,
    input logic [NUM_LEDS-1:0] evt,
    input logic [NUM_LEDS-1:0] fblink,
    input logic [NUM_LEDS-1:0] active,
    input logic [NUM_LEDS-1:0] led_o
);

    for (genvar g = 0; g < NUM_LEDS; g++) begin : g_chk
        AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !live |=> led_o[g] == ~$past(pol[g])); // R5

        AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !en[g] |=> led_o[g] == ~$past(pol[g])); // R4

        AST_STEADY_LIT: assert property (@(posedge clk) disable iff (!rst_n)
            (live && en[g] && !active[g] && steady[g]) |=> led_o[g] == $past(pol[g])); // R2

        AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
            (live && en[g] && !active[g] && !steady[g]) |=> led_o[g] != $past(pol[g])); // R3

        AST_BLINK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(active[g]) |-> $past(evt[g] || fblink[g])); // R6

        AST_FORCE_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (active[g] && fblink[g]) |=> active[g]); // R9
    end

endmodule

bind eth_led_ctrl eth_led_ctrl_chk #(
    .NUM_LEDS (NUM_LEDS)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .live   (live),
    .en     (en_vec),
    .pol    (pol_vec),
    .steady (steady_vec),
    .evt    (evt_vec),
    .fblink (fblink_vec),
    .active (active_vec),
    .led_o  (led_o)
);

// File: tb/eth_led_ctrl_test.sv
module eth_led_ctrl_test;

    localparam int NL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        link_up = 1'b0;
    logic [1:0]  link_speed = 2'd3;
    logic [2:0]  act_tx = '0;
    logic [2:0]  act_rx = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [2:0]  led_o;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    eth_led_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .link_up    (link_up),
        .link_speed (link_speed),
        .act_tx     (act_tx),
        .act_rx     (act_rx),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .led_o      (led_o)
    );

    always #10ns clk = ~clk;

    // ---------------- reference model built from the requirements ----------------
    localparam logic [15:0] ST_KEEP = 16'hC143;
    localparam logic [15:0] AC_KEEP = 16'h0E0F;

    logic [15:0] m_ctrl, m_bdur, m_odur;
    logic [15:0] m_st [NL];
    logic [15:0] m_ac [NL];
    logic        m_act [NL];
    logic        m_pend [NL];
    int          m_cnt [NL];
    logic [2:0]  m_led;

    function automatic logic m_has_rule(int i);
        return m_st[i][0] | m_st[i][1] | m_st[i][8] |
               (|m_ac[i][3:0]) | m_ac[i][10] | m_ac[i][11];
    endfunction

    function automatic logic m_steady(int i);
        logic m;
        m = 1'b0;
        if (link_up) begin
            if (link_speed == 2'd0) m = m_st[i][1];
            if (link_speed == 2'd1) m = m_st[i][0];
            if (link_speed == 2'd2) m = m_st[i][8];
        end
        return m | (m_st[i][6] & ~m_has_rule(i));
    endfunction

    function automatic logic m_evt(int i);
        logic e;
        e = (act_tx[0] & m_ac[i][2]) | (act_rx[0] & m_ac[i][3]) |
            (act_tx[1] & m_ac[i][0]) | (act_rx[1] & m_ac[i][1]) |
            (act_tx[2] & m_ac[i][10]) | (act_rx[2] & m_ac[i][11]);
        return link_up & e;
    endfunction

    function automatic logic m_fblink(int i);
        return m_ac[i][9] & ~m_has_rule(i);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 16'h8009;
            m_bdur = 16'd1562;
            m_odur = 16'd781;
            m_st[0] = 16'hC103; m_st[1] = 16'hC101; m_st[2] = 16'hC102;
            m_ac[0] = 16'h0000; m_ac[1] = 16'h0C03; m_ac[2] = 16'h0C0C;
            for (int i = 0; i < NL; i++) begin
                m_act[i] = 1'b0; m_pend[i] = 1'b0; m_cnt[i] = 0;
            end
            m_led = '0;
        end else begin
            logic live, te;
            live = m_ctrl[15] && (m_ctrl[1:0] != 2'b00);
            te   = tick && m_ctrl[3];
            for (int i = 0; i < NL; i++) begin
                logic lit, e, fb;
                lit = m_act[i] ? (m_cnt[i] < int'(m_odur)) : m_steady(i);
                m_led[i] = (live && m_st[i][15] && lit) ? m_st[i][14] : ~m_st[i][14];
                e  = m_evt(i);
                fb = m_fblink(i);
                if (!m_act[i]) begin
                    if (e || fb) begin
                        m_act[i] = 1'b1; m_pend[i] = 1'b0; m_cnt[i] = 0;
                    end
                end else if (te) begin
                    if (m_cnt[i] + 1 >= int'(m_bdur)) begin
                        if (!(m_pend[i] || e || fb)) m_act[i] = 1'b0;
                        m_pend[i] = 1'b0; m_cnt[i] = 0;
                    end else begin
                        m_cnt[i] = m_cnt[i] + 1;
                        if (e) m_pend[i] = 1'b1;
                    end
                end else if (e) begin
                    m_pend[i] = 1'b1;
                end
            end
            if (cfg_we) begin
                if (cfg_addr == 4'd0) m_ctrl = cfg_wdata & 16'h800B;
                if (cfg_addr == 4'd1) m_bdur = cfg_wdata;
                if (cfg_addr == 4'd2) m_odur = cfg_wdata;
                for (int i = 0; i < NL; i++) begin
                    if (cfg_addr == 4'(4 + 2 * i)) m_st[i] = cfg_wdata & ST_KEEP;
                    if (cfg_addr == 4'(5 + 2 * i)) m_ac[i] = cfg_wdata & AC_KEEP;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input logic ok, input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: led_o actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: compare at the falling edge, return so the caller drives the next inputs
    task automatic step();
        @(negedge clk);
        chk(led_o === m_led, cur_req, led_o, m_led);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_tx(input int spd);
        act_tx = 3'(1 << spd);
        step();
        act_tx = '0;
    endtask

    task automatic set_link(input logic up, input logic [1:0] spd);
        link_up = up; link_speed = spd;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20250406));
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(led_o === 3'b000, "R1 during reset", led_o, 3'b000);
        rst_n = 1'b1;
        tick  = 1'b1;
        step();
        chk(led_o === 3'b000, "R1 after reset", led_o, 3'b000);
        run(4);

        // R11: defaults at every speed, then default blink timing on LED1
        cur_req = "R11";
        for (int s = 0; s < 4; s++) begin
            set_link(1'b1, 2'(s));
            run(4);
        end
        set_link(1'b1, 2'd2);
        step(); step();
        chk(led_o === 3'b111, "R11 2500 all lit", led_o, 3'b111);
        pulse_tx(2);
        run(1700);

        // R2: steady rules per speed code, with traffic blinking disabled
        cur_req = "R2";
        wr(4'd7, 16'h0000);
        wr(4'd9, 16'h0000);
        wr(4'd6, 16'hC100);
        wr(4'd8, 16'hC002);
        for (int s = 0; s < 4; s++) begin
            set_link(1'b1, 2'(s));
            run(3);
        end
        set_link(1'b0, 2'd1);
        step(); step();
        chk(led_o === 3'b000, "R2 link down", led_o, 3'b000);

        // R6: short periods, single pulses on each speed and direction
        cur_req = "R6";
        wr(4'd1, 16'd6);
        wr(4'd2, 16'd3);
        wr(4'd7, 16'h0C0F);
        set_link(1'b1, 2'd0);
        for (int s = 0; s < 3; s++) begin
            pulse_tx(s);
            run(9);
            act_rx = 3'(1 << s);
            step();
            act_rx = '0;
            run(9);
        end

        // R7: pulses inside the period keep the pattern going
        cur_req = "R7";
        for (int k = 0; k < 6; k++) begin
            pulse_tx(1);
            run(3);
        end
        run(15);

        // R3: polarity inverted on LED0 with link down
        cur_req = "R3";
        set_link(1'b0, 2'd0);
        wr(4'd4, 16'h8103);
        step(); step();
        chk(led_o[0] === 1'b1, "R3 inactive high", {2'b00, led_o[0]}, 3'b001);
        set_link(1'b1, 2'd1);
        run(4);
        wr(4'd4, 16'hC103);

        // R4: enable off
        cur_req = "R4";
        wr(4'd6, 16'h4101);
        set_link(1'b1, 2'd2);
        run(4);
        wr(4'd6, 16'hC101);

        // R5: mode 00, then external bit cleared
        cur_req = "R5";
        wr(4'd0, 16'h8008);
        run(4);
        wr(4'd0, 16'h000B);
        run(3);
        chk(led_o === 3'b000, "R5 all inactive", led_o, 3'b000);
        wr(4'd0, 16'h8009);
        run(2);

        // R8: force-on alone, then masked by a rule
        cur_req = "R8";
        set_link(1'b0, 2'd0);
        wr(4'd9, 16'h0000);
        wr(4'd8, 16'hC040);
        run(3);
        chk(led_o[2] === 1'b1, "R8 forced on", {led_o[2], 2'b00}, 3'b100);
        wr(4'd8, 16'hC042);
        run(3);

        // R9: force-blink alone, then masked by a rule
        cur_req = "R9";
        wr(4'd6, 16'hC000);
        wr(4'd7, 16'h0200);
        run(30);
        wr(4'd7, 16'h0201);
        run(20);

        // R10: timing frozen while a period runs
        cur_req = "R10";
        wr(4'd7, 16'h0C0F);
        set_link(1'b1, 2'd1);
        pulse_tx(1);
        run(2);
        wr(4'd0, 16'h8001);
        run(12);
        wr(4'd0, 16'h8009);
        run(10);

        // Random traffic and configuration
        cur_req = "R6 R7 random";
        for (int k = 0; k < 4000; k++) begin
            tick   = ($urandom % 4) != 0;
            act_tx = 3'($urandom % 8) & 3'($urandom % 8) & 3'($urandom % 8);
            act_rx = 3'($urandom % 8) & 3'($urandom % 8) & 3'($urandom % 8);
            if ($urandom % 64 == 0) set_link(1'($urandom % 4 != 0), 2'($urandom % 4));
            if ($urandom % 50 == 0) begin
                int a;
                a = $urandom % 10;
                cfg_we = 1'b1;
                cfg_addr = 4'(a);
                if (a == 1 || a == 2) cfg_wdata = 16'($urandom % 13);
                else if (a == 0) cfg_wdata = ($urandom % 8 == 0) ? 16'h8000 : 16'h8009 ^ 16'($urandom % 2 << 3);
                else cfg_wdata = 16'($urandom) | 16'h8000;
            end else begin
                cfg_we = 1'b0;
            end
            step();
        end
        cfg_we = 1'b0;
        run(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4ms;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule